// File: doc/BRIEF.md
# Vertical sync coast generator

This block keeps a vertical timing reference alive when the incoming video goes away. While the video-present input is high, each rising edge of the incoming vertical sync becomes a one-clock output pulse. The block also measures the spacing between consecutive rising edges in clock cycles and keeps the most recent measurement.

When video-present drops, the block switches to coasting. It produces its own one-clock pulses at a fixed spacing, and it raises a coasting flag for the whole time it coasts. A 2-bit mode input picks the coast spacing:
- the last measured input field period;
- a forced 50 Hz period;
- a forced 60 Hz period.

Both forced periods are derived from a clock-frequency parameter. The block does not decide whether video is present; an upstream detector supplies that flag.

Top module: `vsync_coaster`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `vs_out` and `coasting` are 0.
- R2: While `vid_ok` is 1, every rising edge of `vs_in` gives exactly one `vs_out` pulse, one clock wide, one cycle later. This holds however many cycles `vs_in` stays high.
- R3: `coasting` equals the inverse of `vid_ok` sampled one cycle earlier.
- R4: When coasting begins, the first generated pulse comes exactly one coast period after the last pulse passed through from the input. Each generated pulse restarts the period count.
- R5: In mode `2'b00` (auto), the coast period is the spacing in clock cycles between the last two input rising edges measured while video was present.
- R6: In auto mode with no measurement since reset, the coast period is CLK_HZ/60 cycles.
- R7: Mode `2'b01` forces a coast period of CLK_HZ/50 cycles.
- R8: Mode `2'b10` forces a coast period of CLK_HZ/60 cycles.
- R9: Mode `2'b11` behaves exactly as mode `2'b00`.
- R10: While coasting, `vs_in` has no effect on `vs_out`.
- R11: After coasting, the first input rising edge only restarts the period count. The kept measurement updates from the second edge onward, so a loss right after one edge reuses the old period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vs_in | input | 1 | Incoming vertical sync, active high, any width |
| vid_ok | input | 1 | High while the input video is valid |
| mode | input | 2 | Coast rate select: 00 auto, 01 50 Hz, 10 60 Hz, 11 as auto |
| vs_out | output | 1 | One-clock vertical sync pulse, passed through or generated |
| coasting | output | 1 | High while the block generates its own pulses |

## Verification
The bench measures the spacing between output pulses around the moment video drops. An off-by-one in the period counter would make the first generated pulse come one cycle early or late, and so would a restart of the count at the loss instead of at the last pulse.

It switches mode while coasting and toggles the sync input during coasting. A design that decodes a mode wrongly would produce the wrong spacing, and one that leaks the input into the output would show pulses where the reference has none.

It drops video right after a single edge following a coast period. A design that measured from the last generated pulse would latch a bogus period at that point.

It also coasts straight out of reset, which exposes a missing 60 Hz fallback.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   typedef enum logic [1:0] {
      MODE_AUTO  = 2'b00,
      MODE_FIX50 = 2'b01,
      MODE_FIX60 = 2'b10,
      MODE_SPARE = 2'b11
   } coast_mode_e;
endpackage

// File: rtl/vsc_edge.sv
module vsc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_i;
   end

   assign rise_o = sync_i & ~prev_q;
endmodule

// File: rtl/vsc_rate_sel.sv
module vsc_rate_sel #(
   parameter int CNT_W = 12,
   parameter int PER50 = 1200,
   parameter int PER60 = 1000
) (
   input  logic [1:0]       mode_i,
   input  logic             meas_valid_i,
   input  logic [CNT_W-1:0] meas_per_i,
   output logic [CNT_W-1:0] target_o
);
   import vsc_pkg::*;

   localparam logic [CNT_W-1:0] T50 = CNT_W'(PER50);
   localparam logic [CNT_W-1:0] T60 = CNT_W'(PER60);

   coast_mode_e mode_e;
   assign mode_e = coast_mode_e'(mode_i);

   always_comb begin
      case (mode_e)
         MODE_FIX50: target_o = T50;
         MODE_FIX60: target_o = T60;
         MODE_AUTO,
         MODE_SPARE: target_o = meas_valid_i ? meas_per_i : T60;
         default:    target_o = T60;
      endcase
   end
endmodule

// File: rtl/vsc_timer.sv
module vsc_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             present_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             fire_o,
   output logic             meas_valid_o,
   output logic [CNT_W-1:0] meas_per_o
);
   logic [CNT_W-1:0] gap_q;
   logic [CNT_W-1:0] per_q;
   logic             valid_q;
   logic             have_q;
   logic [CNT_W:0]   gap_nx;
   logic [CNT_W-1:0] gap_sat;
   logic             at_lim;

   assign gap_nx  = {1'b0, gap_q} + (CNT_W+1)'(1);
   assign gap_sat = (&gap_q) ? gap_q : gap_nx[CNT_W-1:0];
   assign at_lim  = gap_nx >= {1'b0, target_i};
   assign fire_o  = present_i ? rise_i : at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q   <= '0;
         per_q   <= '0;
         valid_q <= 1'b0;
         have_q  <= 1'b0;
      end else if (present_i) begin
         if (rise_i) begin
            gap_q  <= '0;
            have_q <= 1'b1;
            if (have_q) begin
               per_q   <= gap_sat;
               valid_q <= 1'b1;
            end
         end else begin
            gap_q <= gap_sat;
         end
      end else if (at_lim) begin
         gap_q  <= '0;
         have_q <= 1'b0;
      end else begin
         gap_q <= gap_sat;
      end
   end

   assign meas_valid_o = valid_q;
   assign meas_per_o   = per_q;

   // an edge can only follow a low cycle, so a measured period is at least 2
   assert_period_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> per_q >= CNT_W'(2));

   // the first edge after a coast interval must not touch the stored period
   assert_restart_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
      present_i && rise_i && !have_q |=> $stable(per_q));

   // a generated pulse restarts the period count
   assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !present_i && fire_o |=> gap_q == '0);
endmodule

// File: rtl/vsync_coaster.sv
module vsync_coaster #(
   parameter int CLK_HZ = 27_000_000,
   parameter int CNT_W  = $clog2(CLK_HZ / 50) + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vs_in,
   input  logic       vid_ok,
   input  logic [1:0] mode,
   output logic       vs_out,
   output logic       coasting
);
   localparam int PER50 = CLK_HZ / 50;
   localparam int PER60 = CLK_HZ / 60;

   generate
      if (CLK_HZ < 600) begin : g_bad_clk
         $error("vsync_coaster: CLK_HZ too small for a usable coast period");
      end
      if (CNT_W < $clog2(PER50 + 1)) begin : g_bad_width
         $error("vsync_coaster: CNT_W cannot hold the 50 Hz period");
      end
   endgenerate

   logic             rise;
   logic             fire;
   logic             meas_valid;
   logic [CNT_W-1:0] meas_per;
   logic [CNT_W-1:0] target;
   logic             vs_q;
   logic             coast_q;

   vsc_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (vs_in),
      .rise_o (rise)
   );

   vsc_rate_sel #(
      .CNT_W (CNT_W),
      .PER50 (PER50),
      .PER60 (PER60)
   ) u_rate (
      .mode_i       (mode),
      .meas_valid_i (meas_valid),
      .meas_per_i   (meas_per),
      .target_o     (target)
   );

   vsc_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .present_i    (vid_ok),
      .rise_i       (rise),
      .target_i     (target),
      .fire_o       (fire),
      .meas_valid_o (meas_valid),
      .meas_per_o   (meas_per)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q    <= 1'b0;
         coast_q <= 1'b0;
      end else begin
         vs_q    <= fire;
         coast_q <= ~vid_ok;
      end
   end

   assign vs_out   = vs_q;
   assign coasting = coast_q;

   assert_one_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vs_out |=> !vs_out);

   assert_pass_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vid_ok && rise |=> vs_out);

   assert_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> coasting == !$past(vid_ok));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !vs_out && !coasting);
endmodule

// File: tb/sim_vsync_coaster.sv
module sim_vsync_coaster;
   localparam int CLK_HZ = 60000;
   localparam int CNT_W  = 12;
   localparam int P50    = CLK_HZ / 50;
   localparam int P60    = CLK_HZ / 60;
   localparam int GMAX   = (1 << CNT_W) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vs_in = 1'b0;
   logic       vid_ok = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       vs_out;
   logic       coasting;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   string phase_req = "R1";
   int pq[$];

   // reference model state
   int m_gap = 0, m_per = 0;
   bit m_valid = 0, m_have = 0, m_prev = 0;
   bit e_vs = 0, e_co = 0;

   vsync_coaster #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .vid_ok(vid_ok),
      .mode(mode), .vs_out(vs_out), .coasting(coasting)
   );

   always #2 clk = ~clk;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gap = 0; m_per = 0; m_valid = 0; m_have = 0; m_prev = 0;
         e_vs = 0; e_co = 0;
      end else begin
         bit edge_seen;
         int tgt;
         cyc++;
         edge_seen = vs_in && !m_prev;
         m_prev = vs_in;
         e_co = !vid_ok;
         if (vid_ok) begin
            e_vs = edge_seen;
            if (edge_seen) begin
               if (m_have) begin
                  m_per = (m_gap == GMAX) ? GMAX : m_gap + 1;
                  m_valid = 1;
               end
               m_gap = 0;
               m_have = 1;
            end else if (m_gap < GMAX) m_gap++;
         end else begin
            if (mode == 2'b01) tgt = P50;
            else if (mode == 2'b10) tgt = P60;
            else tgt = m_valid ? m_per : P60;
            if (m_gap + 1 >= tgt) begin
               e_vs = 1; m_gap = 0; m_have = 0;
            end else begin
               e_vs = 0;
               if (m_gap < GMAX) m_gap++;
            end
         end
      end
   end

   always @(negedge clk) begin
      check(vs_out == e_vs, rst_n ? phase_req : "R1", vs_out, e_vs);
      check(coasting == e_co, rst_n ? "R3" : "R1", coasting, e_co);
      if (vs_out) pq.push_back(cyc);
   end

   always @(posedge clk) begin
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_vs(int per, int n);
      for (int i = 0; i < n; i++) begin
         vs_in = 1'b1;
         idle(3);
         vs_in = 1'b0;
         idle(i < n - 1 ? per - 3 : 10);
      end
   endtask

   task automatic check_gap(int a, int b, int exp, string req);
      if (pq.size() <= b) check(1'b0, req, -1, exp);
      else check(pq[b] - pq[a] == exp, req, pq[b] - pq[a], exp);
   endtask

   initial begin
      idle(5);
      check(vs_out == 1'b0, "R1", vs_out, 0);
      check(coasting == 1'b0, "R1", coasting, 0);
      rst_n = 1'b1;
      idle(20);

      // R2 passthrough, then R4/R5 coast from measured period
      phase_req = "R2";
      pq.delete();
      send_vs(700, 4);
      phase_req = "R4";
      vid_ok = 1'b0;
      idle(2200);
      check_gap(0, 1, 700, "R2");
      check_gap(3, 4, 700, "R4");
      check_gap(4, 5, 700, "R5");

      // R7 forced 50 Hz
      phase_req = "R7";
      mode = 2'b01;
      idle(50);
      pq.delete();
      idle(3000);
      check_gap(0, 1, P50, "R7");

      // R8 forced 60 Hz
      phase_req = "R8";
      mode = 2'b10;
      idle(50);
      pq.delete();
      idle(2500);
      check_gap(0, 1, P60, "R8");

      // R9 spare code as auto, with input toggling (R10)
      phase_req = "R10";
      mode = 2'b11;
      idle(50);
      pq.delete();
      send_vs(300, 5);
      idle(1000);
      check_gap(0, 1, 700, "R9");
      check_gap(1, 2, 700, "R10");

      // R11 single edge after return keeps the old period
      phase_req = "R11";
      mode = 2'b00;
      pq.delete();
      vid_ok = 1'b1;
      send_vs(500, 1);
      vid_ok = 1'b0;
      idle(1600);
      check_gap(0, 1, 700, "R11");
      check_gap(1, 2, 700, "R11");

      pq.delete();
      vid_ok = 1'b1;
      send_vs(500, 3);
      vid_ok = 1'b0;
      idle(1200);
      check_gap(0, 1, 500, "R2");
      check_gap(2, 3, 500, "R11");

      // R6 fallback with no measurement
      phase_req = "R6";
      rst_n = 1'b0;
      vid_ok = 1'b0;
      mode = 2'b00;
      idle(3);
      check(vs_out == 1'b0, "R1", vs_out, 0);
      pq.delete();
      rst_n = 1'b1;
      idle(2200);
      check_gap(0, 1, P60, "R6");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule